// File: doc/BRIEF.md
# Link Interface Wake-Up Sequencer

This block sits on the physical-layer side of a point-to-point link between a physical layer and a link layer. The link layer signals that it wants the interface by holding a power-status line high. When that line goes high, the block brings the interface back into normal operation in a fixed, cycle-numbered order. First it re-enables the system clock it supplies to the link, if that clock had been stopped. It then drives the 2-bit control bus and the data bus all-low for one cycle. On a fixed later cycle it shows a Receive indication with all-ones data. After that it settles on Idle and raises a ready flag, from which point link requests are accepted.

The power-status line may drop at any time. When it does, the sequence stops and the interface falls back to a reset state with the clock still running. If the line stays low for a set number of cycles, the interface becomes fully disabled and the clock enable drops. Waking from reset skips the clock lead-in cycle that waking from disabled needs. In differentiated mode the block releases both buses to high impedance whenever it is not showing a sequence event. In normal mode it keeps driving them.

Top module: `link_wake_seq`

## Requirements
- R1: After `rst_n` is released the block is disabled: `sysclk_en`=0, `ctl_oe`=`d_oe`=0, `ready`=0. An undriven bus reads as value zero on `ctl_o` and `d_o`.
- R2: When `lps` is sampled high while disabled, `sysclk_en` is 1 from the next cycle on. That first enabled cycle is a lead-in with the buses undriven, and cycle 1 follows it.
- R3: In sequence cycle 1 both buses are driven (`ctl_oe`=`d_oe`=1) with `ctl_o`=2'b00 and `d_o`=0, for exactly one cycle.
- R4: In sequence cycles 2 to `RECV_CYCLE`-1 the buses are undriven when `diff_mode`=1. When `diff_mode`=0 they are driven with zeros.
- R5: In sequence cycle `RECV_CYCLE` (8 by default) the buses are driven with the Receive code `ctl_o`=2'b01 and `d_o` all ones, for exactly one cycle.
- R6: In cycle `RECV_CYCLE`+1 the buses are driven with the Idle code `ctl_o`=2'b00 and `d_o`=0, and `ready` rises in that cycle.
- R7: After cycle `RECV_CYCLE`+1, while `lps` stays high, `ready` stays 1 and Idle with zero data is shown. The buses are undriven when `diff_mode`=1 and driven when `diff_mode`=0.
- R8: `req_accept` follows `lreq` only while `ready`=1. A request arriving earlier is ignored.
- R9: `lps` sampled low in any enabled state aborts the sequence. From the next cycle `ready`=0 and the buses are undriven, while `sysclk_en` stays 1 until R10 applies.
- R10: After `OFF_DELAY` consecutive low samples of `lps` (at least 2), the block is disabled again: `sysclk_en`=0. Fewer low samples leave it in reset.
- R11: When `lps` is sampled high in reset (not disabled), sequence cycle 1 follows in the very next cycle, with no lead-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, one tick per system-clock period |
| rst_n | input | 1 | Active-low asynchronous reset |
| lps | input | 1 | Link power-status, high requests the interface |
| diff_mode | input | 1 | 1 selects differentiated mode (buses released when idle) |
| lreq | input | 1 | Link request line |
| sysclk_en | output | 1 | Enable for the supplied system clock |
| ctl_o | output | 2 | Control bus value (Idle 00, Receive 01) |
| ctl_oe | output | 1 | Control bus output enable |
| d_o | output | DATA_W | Data bus value |
| d_oe | output | 1 | Data bus output enable |
| ready | output | 1 | Initialization complete |
| req_accept | output | 1 | Link request accepted this cycle |

## Verification
The bench builds the block with `OFF_DELAY`=6, `RECV_CYCLE`=8 and `DATA_W`=8. The short off delay lets random power-status drops reach both the reset and the disabled path within a few cycles. This exercises the lead-in and no-lead-in wake paths, including the boundary of exactly `OFF_DELAY`-1 and `OFF_DELAY` low samples. The default Receive cycle keeps every numbered sequence cycle visible, and `diff_mode` toggles across runs so both bus-release behaviours are compared against a cycle model kept in the bench.

// File: rtl/lw_pkg.sv
`timescale 1ns/1ps
package lw_pkg;

  typedef enum logic [2:0] {
    PH_OFF  = 3'd0,
    PH_HOLD = 3'd1,
    PH_LEAD = 3'd2,
    PH_SEQ  = 3'd3,
    PH_LIVE = 3'd4
  } phase_e;

  localparam logic [1:0] CTL_IDLE = 2'b00;
  localparam logic [1:0] CTL_RECV = 2'b01;

  // whether the physical layer drives the buses in this phase and cycle
  function automatic logic bus_on(phase_e ph, int unsigned cyc,
                                  int unsigned recv_cyc, logic diff);
    logic on;
    case (ph)
      PH_SEQ:  on = (cyc == 1) || (cyc >= recv_cyc) || !diff;
      PH_LIVE: on = !diff;
      default: on = 1'b0;
    endcase
    return on;
  endfunction

  function automatic logic is_recv(phase_e ph, int unsigned cyc,
                                   int unsigned recv_cyc);
    return (ph == PH_SEQ) && (cyc == recv_cyc);
  endfunction

  function automatic logic is_ready(phase_e ph, int unsigned cyc,
                                    int unsigned recv_cyc);
    return (ph == PH_LIVE) || ((ph == PH_SEQ) && (cyc == recv_cyc + 1));
  endfunction

endpackage

// File: rtl/lw_low_timer.sv
`timescale 1ns/1ps
module lw_low_timer #(
  parameter int OFF_DELAY = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lps,
  input  logic active,
  output logic off_hit
);
  localparam int LW = $clog2(OFF_DELAY + 1);
  localparam logic [LW-1:0] HIT_AT = LW'(OFF_DELAY - 1);
  localparam logic [LW-1:0] SAT_AT = LW'(OFF_DELAY);

  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               low_cnt <= '0;
    else if (!active || lps)  low_cnt <= '0;
    else if (low_cnt != SAT_AT) low_cnt <= low_cnt + 1'b1;
  end

  assign off_hit = active && !lps && (low_cnt == HIT_AT);

  // R10: the count never passes its saturation value
  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt <= SAT_AT);

endmodule

// File: rtl/lw_phase_fsm.sv
`timescale 1ns/1ps
module lw_phase_fsm
  import lw_pkg::*;
#(
  parameter int RECV_CYCLE = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lps,
  input  logic             off_hit,
  output phase_e           phase,
  output logic [CNT_W-1:0] cyc,
  output logic             active
);
  localparam logic [CNT_W-1:0] LAST_CYC = CNT_W'(RECV_CYCLE + 1);

  phase_e           nx_phase;
  logic [CNT_W-1:0] nx_cyc;

  always_comb begin
    nx_phase = phase;
    nx_cyc   = cyc;
    if (!lps) begin
      nx_cyc = '0;
      if (phase == PH_OFF || off_hit) nx_phase = PH_OFF;
      else                            nx_phase = PH_HOLD;
    end else begin
      case (phase)
        PH_OFF: begin
          nx_phase = PH_LEAD;
          nx_cyc   = '0;
        end
        PH_HOLD, PH_LEAD: begin
          nx_phase = PH_SEQ;
          nx_cyc   = CNT_W'(1);
        end
        PH_SEQ: begin
          if (cyc == LAST_CYC) begin
            nx_phase = PH_LIVE;
            nx_cyc   = '0;
          end else begin
            nx_cyc = cyc + 1'b1;
          end
        end
        default: nx_phase = PH_LIVE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_OFF;
      cyc   <= '0;
    end else begin
      phase <= nx_phase;
      cyc   <= nx_cyc;
    end
  end

  assign active = (phase != PH_OFF);

  // R11: waking from reset lands on cycle 1 without a lead-in
  p_hold_wake_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HOLD && lps) |=> (phase == PH_SEQ && cyc == CNT_W'(1)));

  // R2: the lead-in lasts one cycle when lps stays high
  p_lead_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LEAD && lps) |=> (phase == PH_SEQ && cyc == CNT_W'(1)));

  // R4: sequence counter stays inside its range
  p_cyc_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SEQ) |-> (cyc >= CNT_W'(1) && cyc <= LAST_CYC));

endmodule

// File: rtl/lw_bus_map.sv
`timescale 1ns/1ps
module lw_bus_map
  import lw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RECV_CYCLE = 8,
  parameter int CNT_W = 4
) (
  input  phase_e             phase,
  input  logic [CNT_W-1:0]   cyc,
  input  logic               diff_mode,
  output logic               sysclk_en,
  output logic [1:0]         ctl_o,
  output logic               ctl_oe,
  output logic [DATA_W-1:0]  d_o,
  output logic               d_oe,
  output logic               ready
);
  logic drive, recv;

  always_comb begin
    drive     = bus_on(phase, 32'(cyc), RECV_CYCLE, diff_mode);
    recv      = is_recv(phase, 32'(cyc), RECV_CYCLE);
    sysclk_en = (phase != PH_OFF);
    ctl_oe    = drive;
    d_oe      = drive;
    ctl_o     = recv ? CTL_RECV : CTL_IDLE;
    d_o       = recv ? {DATA_W{1'b1}} : '0;
    ready     = is_ready(phase, 32'(cyc), RECV_CYCLE);
  end

endmodule

// File: rtl/link_wake_seq.sv
`timescale 1ns/1ps
module link_wake_seq
  import lw_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int RECV_CYCLE = 8,
  parameter int OFF_DELAY  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lps,
  input  logic              diff_mode,
  input  logic              lreq,
  output logic              sysclk_en,
  output logic [1:0]        ctl_o,
  output logic              ctl_oe,
  output logic [DATA_W-1:0] d_o,
  output logic              d_oe,
  output logic              ready,
  output logic              req_accept
);
  localparam int CNT_W = $clog2(RECV_CYCLE + 2);

  phase_e           phase;
  logic [CNT_W-1:0] cyc;
  logic             active;
  logic             off_hit;

  lw_low_timer #(.OFF_DELAY(OFF_DELAY)) u_timer (
    .clk(clk), .rst_n(rst_n), .lps(lps), .active(active), .off_hit(off_hit)
  );

  lw_phase_fsm #(.RECV_CYCLE(RECV_CYCLE), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .lps(lps), .off_hit(off_hit),
    .phase(phase), .cyc(cyc), .active(active)
  );

  lw_bus_map #(.DATA_W(DATA_W), .RECV_CYCLE(RECV_CYCLE), .CNT_W(CNT_W)) u_bus (
    .phase(phase), .cyc(cyc), .diff_mode(diff_mode), .sysclk_en(sysclk_en),
    .ctl_o(ctl_o), .ctl_oe(ctl_oe), .d_o(d_o), .d_oe(d_oe), .ready(ready)
  );

  assign req_accept = ready && lreq;

  // R2: clock enable follows a wake request from disabled
  p_clock_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && lps) |=> (sysclk_en && !ctl_oe));

  // R5: Receive lasts one cycle, then Idle is driven
  p_recv_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_oe && ctl_o == CTL_RECV && lps) |=> (ready && ctl_oe && ctl_o == CTL_IDLE));

  // R6: ready only rises right after a driven Receive cycle
  p_ready_after_recv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(ctl_o) == CTL_RECV && $past(d_oe)));

  // R9: a low power-status sample removes ready
  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lps |=> !ready);

  // R10: the timeout switches the clock off
  p_off_after_timeout_r10: assert property (@(posedge clk) disable iff (!rst_n)
    off_hit |=> (!sysclk_en && !ctl_oe && !d_oe));

endmodule

// File: tb/test_link_wake_seq.sv
`timescale 1ns/1ps
module test_link_wake_seq;
  localparam int DW = 8;
  localparam int RX = 8;
  localparam int OD = 6;

  logic clk = 1'b0;
  logic rst_n, lps, diff_mode, lreq;
  logic sysclk_en, ctl_oe, d_oe, ready, req_accept;
  logic [1:0] ctl_o;
  logic [DW-1:0] d_o;

  int checks = 0;
  int errors = 0;
  int m_ph, m_cyc, m_low;  // 0 off, 1 hold, 2 lead, 3 seq, 4 live

  always #2.5 clk = ~clk;

  link_wake_seq #(.DATA_W(DW), .RECV_CYCLE(RX), .OFF_DELAY(OD)) i_link_wake_seq (
    .clk(clk), .rst_n(rst_n), .lps(lps), .diff_mode(diff_mode), .lreq(lreq),
    .sysclk_en(sysclk_en), .ctl_o(ctl_o), .ctl_oe(ctl_oe), .d_o(d_o),
    .d_oe(d_oe), .ready(ready), .req_accept(req_accept)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic void model_step(logic l);
    if (!l) begin
      m_low++;
      m_cyc = 0;
      if (m_ph != 0) m_ph = (m_low >= OD) ? 0 : 1;
    end else begin
      m_low = 0;
      case (m_ph)
        0: begin m_ph = 2; m_cyc = 0; end
        1, 2: begin m_ph = 3; m_cyc = 1; end
        3: if (m_cyc == RX + 1) begin m_ph = 4; m_cyc = 0; end else m_cyc++;
        default: m_ph = 4;
      endcase
    end
  endfunction

  function automatic string tag_of();
    case (m_ph)
      0: return "R10";
      1: return "R9";
      2: return "R2";
      3: if (m_cyc == 1) return "R3";
         else if (m_cyc < RX) return "R4";
         else if (m_cyc == RX) return "R5";
         else return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic compare();
    int e_on, e_rx, e_rdy;
    string t;
    t = tag_of();
    e_on  = (m_ph == 3) ? ((m_cyc == 1 || m_cyc >= RX || !diff_mode) ? 1 : 0)
          : (m_ph == 4) ? (diff_mode ? 0 : 1) : 0;
    e_rx  = (m_ph == 3 && m_cyc == RX) ? 1 : 0;
    e_rdy = (m_ph == 4 || (m_ph == 3 && m_cyc == RX + 1)) ? 1 : 0;
    check(t, "sysclk_en", int'(sysclk_en), (m_ph != 0) ? 1 : 0);
    check(t, "ctl_oe", int'(ctl_oe), e_on);
    check(t, "d_oe", int'(d_oe), e_on);
    check(t, "ctl_o", int'(ctl_o), e_rx ? 1 : 0);
    check(t, "d_o", int'(d_o), e_rx ? ((1 << DW) - 1) : 0);
    check(t, "ready", int'(ready), e_rdy);
    check("R8", "req_accept", int'(req_accept), (e_rdy != 0 && lreq) ? 1 : 0);
  endtask

  task automatic step(logic l, logic dm, logic rq);
    lps = l; diff_mode = dm; lreq = rq;
    @(posedge clk);
    model_step(l);
    @(negedge clk);
    compare();
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; lps = 1'b0; diff_mode = 1'b1; lreq = 1'b0;
    m_ph = 0; m_cyc = 0; m_low = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare();  // R1 reset state
    check("R1", "sysclk_en after reset", int'(sysclk_en), 0);
    step(0, 1, 1);
    step(0, 1, 1);
    // R2..R7 wake from disabled in differentiated mode, lreq held (R8)
    for (int i = 0; i < 13; i++) step(1, 1, 1);
    // R9 abort
    step(0, 1, 1);
    check("R9", "ready after abort", int'(ready), 0);
    check("R9", "sysclk_en after abort", int'(sysclk_en), 1);
    // R11 wake from reset after OD-1 low samples
    for (int i = 0; i < OD - 2; i++) step(0, 0, 0);
    step(1, 0, 0);
    check("R11", "ctl_oe at cycle 1", int'(ctl_oe), 1);
    check("R11", "sysclk_en", int'(sysclk_en), 1);
    // normal mode run to ready
    for (int i = 0; i < 12; i++) step(1, 0, 1);
    // R10 full timeout
    for (int i = 0; i < OD; i++) step(0, 0, 0);
    check("R10", "sysclk_en after timeout", int'(sysclk_en), 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic l, dm;
      l = lps;
      if (lps) begin if ($urandom_range(0, 29) == 0) l = 1'b0; end
      else     begin if ($urandom_range(0, 7) == 0) l = 1'b1; end
      dm = diff_mode;
      if ($urandom_range(0, 49) == 0) dm = ~dm;
      step(l, dm, 1'($urandom_range(0, 1)));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule